// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This block sits behind a bank of comparator channels. It turns their match events into interrupt activity. Each channel has a 5-bit line selector, a trigger type (pulse or held level), an interrupt enable and a message-delivery enable. A global enable gates every channel. From these the unit drives a 32-line interrupt vector, or it queues a memory-write message whose address and data come from a 64-bit per-channel message register.

A legacy takeover mode gives channel 0 fixed line 0 and channel 1 fixed line 8. In this mode the two external legacy interrupt inputs are shut off from those lines, and a legacy-timer-enable output tells the external timer that it has been displaced. All line outputs come from registers and change on the clock edge that samples the stimulus.

Messages are issued one at a time on a valid/ready port. When several channels are pending, the lowest channel index goes first.

Top module: `irq_route_unit`

## Requirements
- R1: With legacy mode off, a delivered pulse event on channel c sets only line chRoute[5c+4:5c], on the edge that samples the event.
- R2: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8, and their route fields have no effect. Channels 2 and up still use their route fields.
- R3: A line is driven only when the channel event is high, the channel enable chIntEn is high and globalEn is high. If either enable is low, the event produces no line activity.
- R4: A pulse-type channel (chLevel=0) raises its line for exactly one cycle for each cycle its event is high.
- R5: A level event on a level-type channel (chLevel=1) sets status bit c even when the channel is disabled. The bit stays set until a cycle with statusClr[c] high and no event on that channel. While the bit is set and the channel is enabled, the line is held high.
- R6: Raising chIntEn while the status bit is already set raises the line on the next edge, with no new event.
- R7: When several channels select the same line, the line is the OR of their contributions.
- R8: With chMsgEn set, a delivered event drives no line. It produces one message: msgAddr equals bits 63:32 of that channel's 64-bit slice of chMsgReg, and msgData equals bits 31:0. The message appears two edges after the event.
- R9: Pending messages are issued lowest channel index first. msgValid, msgAddr and msgData stay stable until msgReady is seen high. A new message may load on the same edge as the transfer.
- R10: With legacy mode off, extTimerIn is ORed onto line 0 and extClockIn onto line 8. With legacy mode on, both are masked and legacyTimerEn is low; otherwise legacyTimerEn is high. After legacy mode is cleared, line 8 again follows extClockIn.
- R11: After reset all lines, all status bits and msgValid are low, and legacyTimerEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Global interrupt enable |
| legacyMode | input | 1 | Legacy takeover mode |
| chEvent | input | NUM_CH | Per-channel match event |
| chIntEn | input | NUM_CH | Per-channel interrupt enable |
| chLevel | input | NUM_CH | 1 = level type, 0 = pulse type |
| chMsgEn | input | NUM_CH | Per-channel message delivery enable |
| chRoute | input | NUM_CH*5 | Line selectors, channel c at bits 5c+4:5c |
| chMsgReg | input | NUM_CH*64 | Message registers, channel c at bits 64c+63:64c (address high, data low) |
| statusClr | input | NUM_CH | Clear strobe for status bits |
| extTimerIn | input | 1 | External legacy timer interrupt |
| extClockIn | input | 1 | External legacy clock interrupt |
| msgReady | input | 1 | Message sink ready |
| irqLines | output | 32 | Interrupt lines |
| status | output | NUM_CH | Level-type status bits |
| legacyTimerEn | output | 1 | Low while legacy mode displaces the external timer |
| msgValid | output | 1 | Message valid |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
Single pulse events are swept across every channel and every route value, first with legacy mode off and then on. A wrong line index, a missing fixed override or a route field leaking through on channels 0 and 1 each shows up as a different wrong bit. Level events are run with the enables raised and lowered in both orders, and two channels share one line and are cleared one at a time. These runs separate held status from pulses and show whether an enable applied late takes effect. Message runs fire three channels in the same cycle under backpressure, which exposes wrong ordering, lost requests and values that change while held. The external-input sequences toggle legacy mode to check masking and the return of line 8.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int MAX_CH_IDX_W = 5;
  localparam int LEGACY_LINE_A = 0;
  localparam int LEGACY_LINE_B = 8;

  typedef struct packed {
    logic                    load;
    logic [MAX_CH_IDX_W-1:0] idx;
  } ctrl_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] msgReq,
  input  logic              msgReady,
  output logic              msgValid,
  output ctrl_t             ctrl
);
  logic [NUM_CH-1:0] pendQ, pendD, grantOh;
  logic              validQ, validD, freeSlot, anyPend;
  logic [MAX_CH_IDX_W-1:0] grantIdx;

  always_comb begin
    grantOh  = '0;
    grantIdx = '0;
    anyPend  = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pendQ[c]) begin
        grantIdx = MAX_CH_IDX_W'(c);
        anyPend  = 1'b1;
      end
    end
    if (anyPend) grantOh[grantIdx] = 1'b1;
    freeSlot  = !validQ || msgReady;
    ctrl.load = freeSlot && anyPend;
    ctrl.idx  = grantIdx;
    pendD     = (pendQ & ~(ctrl.load ? grantOh : '0)) | msgReq;
    if (ctrl.load)    validD = 1'b1;
    else if (msgReady) validD = 1'b0;
    else              validD = validQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      validQ <= 1'b0;
    end else begin
      pendQ  <= pendD;
      validQ <= validD;
    end
  end

  assign msgValid = validQ;
endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 32,
  parameter int ROUTE_W   = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    globalEn,
  input  logic                    legacyMode,
  input  logic [NUM_CH-1:0]       chEvent,
  input  logic [NUM_CH-1:0]       chIntEn,
  input  logic [NUM_CH-1:0]       chLevel,
  input  logic [NUM_CH-1:0]       chMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0] chRoute,
  input  logic [NUM_CH*64-1:0]    chMsgReg,
  input  logic [NUM_CH-1:0]       statusClr,
  input  logic                    extTimerIn,
  input  logic                    extClockIn,
  input  ctrl_t                   ctrl,
  output logic [NUM_CH-1:0]       msgReq,
  output logic [NUM_LINES-1:0]    irqLines,
  output logic [NUM_CH-1:0]       status,
  output logic                    legacyTimerEn,
  output logic [31:0]             msgAddr,
  output logic [31:0]             msgData
);
  localparam logic [ROUTE_W-1:0] LINE_A = ROUTE_W'(LEGACY_LINE_A);
  localparam logic [ROUTE_W-1:0] LINE_B = ROUTE_W'(LEGACY_LINE_B);

  logic [NUM_CH-1:0]    statusQ, statusD, gateOk, driveCh;
  logic [ROUTE_W-1:0]   dest [NUM_CH];
  logic [NUM_LINES-1:0] linesD;

  always_comb begin
    statusD = (statusQ & ~statusClr) | (chEvent & chLevel);
    gateOk  = chIntEn & {NUM_CH{globalEn}} & ~chMsgEn;
    driveCh = (statusD & chLevel & gateOk) | (chEvent & ~chLevel & gateOk);
    msgReq  = chEvent & chIntEn & {NUM_CH{globalEn}} & chMsgEn;
  end

  // Per-channel line selection; the legacy override applies to channels 0 and 1.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_dest
    if (c == 0) begin : g_fixA
      assign dest[c] = legacyMode ? LINE_A : chRoute[c*ROUTE_W +: ROUTE_W];
    end else if (c == 1) begin : g_fixB
      assign dest[c] = legacyMode ? LINE_B : chRoute[c*ROUTE_W +: ROUTE_W];
    end else begin : g_free
      assign dest[c] = chRoute[c*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    linesD = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (driveCh[c]) linesD[dest[c]] = 1'b1;
    end
    if (!legacyMode) begin
      linesD[LINE_A] = linesD[LINE_A] | extTimerIn;
      linesD[LINE_B] = linesD[LINE_B] | extClockIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ       <= '0;
      irqLines      <= '0;
      legacyTimerEn <= 1'b1;
      msgAddr       <= '0;
      msgData       <= '0;
    end else begin
      statusQ       <= statusD;
      irqLines      <= linesD;
      legacyTimerEn <= !legacyMode;
      if (ctrl.load) begin
        msgAddr <= chMsgReg[int'(ctrl.idx)*64 + 32 +: 32];
        msgData <= chMsgReg[int'(ctrl.idx)*64 +: 32];
      end
    end
  end

  assign status = statusQ;
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 32,
  parameter int ROUTE_W   = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      globalEn,
  input  logic                      legacyMode,
  input  logic [NUM_CH-1:0]         chEvent,
  input  logic [NUM_CH-1:0]         chIntEn,
  input  logic [NUM_CH-1:0]         chLevel,
  input  logic [NUM_CH-1:0]         chMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0] chRoute,
  input  logic [NUM_CH*64-1:0]      chMsgReg,
  input  logic [NUM_CH-1:0]         statusClr,
  input  logic                      extTimerIn,
  input  logic                      extClockIn,
  input  logic                      msgReady,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic [NUM_CH-1:0]         status,
  output logic                      legacyTimerEn,
  output logic                      msgValid,
  output logic [31:0]               msgAddr,
  output logic [31:0]               msgData
);
  ctrl_t             ctrl;
  logic [NUM_CH-1:0] msgReq;

  irq_route_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .msgReq(msgReq), .msgReady(msgReady),
    .msgValid(msgValid), .ctrl(ctrl)
  );

  irq_route_datapath #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .legacyMode(legacyMode),
    .chEvent(chEvent), .chIntEn(chIntEn), .chLevel(chLevel), .chMsgEn(chMsgEn),
    .chRoute(chRoute), .chMsgReg(chMsgReg), .statusClr(statusClr),
    .extTimerIn(extTimerIn), .extClockIn(extClockIn), .ctrl(ctrl),
    .msgReq(msgReq), .irqLines(irqLines), .status(status),
    .legacyTimerEn(legacyTimerEn), .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 globalEn,
  input logic                 legacyMode,
  input logic [NUM_CH-1:0]    chEvent,
  input logic [NUM_CH-1:0]    statusClr,
  input logic                 extTimerIn,
  input logic                 extClockIn,
  input logic                 msgReady,
  input logic [NUM_LINES-1:0] irqLines,
  input logic [NUM_CH-1:0]    status,
  input logic                 legacyTimerEn,
  input logic                 msgValid,
  input logic [31:0]          msgAddr,
  input logic [31:0]          msgData
);
  localparam logic [NUM_LINES-1:0] LEG_MASK = (NUM_LINES'(1) << 0) | (NUM_LINES'(1) << 8);

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));

  assert_legacy_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    legacyMode |=> !legacyTimerEn);

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> ((irqLines & ~LEG_MASK) == '0));

  assert_legacy_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    legacyMode && !globalEn |=> irqLines == '0);

  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    |(statusClr & ~chEvent) |=> ((status & $past(statusClr & ~chEvent)) == '0));
endmodule

bind irq_route_unit irq_route_checker #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/test_irq_route_unit.sv
`timescale 1ns/100ps
module test_irq_route_unit;
  localparam int NCH = 4;
  logic clk = 0, rstN = 0;
  logic globalEn = 0, legacyMode = 0;
  logic [NCH-1:0] chEvent = 0, chIntEn = 0, chLevel = 0, chMsgEn = 0, statusClr = 0;
  logic [NCH*5-1:0] chRoute = 0;
  logic [NCH*64-1:0] chMsgReg = 0;
  logic extTimerIn = 0, extClockIn = 0, msgReady = 0;
  logic [31:0] irqLines, msgAddr, msgData;
  logic [NCH-1:0] status;
  logic legacyTimerEn, msgValid;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_unit #(.NUM_CH(NCH)) i_irq_route_unit (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setRoute(int c, int r);
    chRoute[c*5 +: 5] = 5'(r);
  endtask

  function automatic logic [31:0] bitOf(int n);
    return 32'd1 << n;
  endfunction

  initial begin
    #300000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R11 reset state
    chk("R11 lines", 64'(irqLines), 0);
    chk("R11 status", 64'(status), 0);
    chk("R11 valid", 64'(msgValid), 0);
    chk("R11 legacyTimerEn", 64'(legacyTimerEn), 1);
    rstN = 1; globalEn = 1; chIntEn = '1;
    tick();

    // R1 / R4 sweep of all channels and routes, legacy off
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 32; r++) begin
        setRoute(c, r); chEvent = NCH'(1) << c;
        tick();
        chk("R1 route sweep", 64'(irqLines), 64'(bitOf(r)));
        chEvent = 0;
        tick();
        chk("R4 one-cycle pulse", 64'(irqLines), 0);
      end
    end

    // R2 legacy override sweep
    legacyMode = 1; tick();
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 32; r += 3) begin
        setRoute(c, r); chEvent = NCH'(1) << c;
        tick();
        chk("R2 legacy route", 64'(irqLines), 64'(bitOf(c == 0 ? 0 : (c == 1 ? 8 : r))));
        chEvent = 0; tick();
      end
    end
    legacyMode = 0; tick();

    // R3 gating
    setRoute(2, 12);
    globalEn = 0; chEvent = 4'b0100; tick();
    chk("R3 global off", 64'(irqLines), 0);
    globalEn = 1; chIntEn = 4'b1011; tick();
    chk("R3 channel off", 64'(irqLines), 0);
    chEvent = 0; chIntEn = '1; tick();
    chk("R3 no event", 64'(irqLines), 0);

    // R5 level hold and clear
    chLevel = 4'b0100; chEvent = 4'b0100; tick();
    chk("R5 level set", 64'(irqLines), 64'(bitOf(12)));
    chk("R5 status set", 64'(status), 4'b0100);
    chEvent = 0; tick(); tick(); tick();
    chk("R5 level held", 64'(irqLines), 64'(bitOf(12)));
    statusClr = 4'b0100; tick(); statusClr = 0;
    chk("R5 cleared line", 64'(irqLines), 0);
    chk("R5 cleared status", 64'(status), 0);

    // R6 late enable
    chIntEn = 4'b1011; chEvent = 4'b0100; tick(); chEvent = 0;
    chk("R6 disabled status still set", 64'(status), 4'b0100);
    chk("R6 disabled no line", 64'(irqLines), 0);
    tick();
    chIntEn = '1; tick();
    chk("R6 reassert on enable", 64'(irqLines), 64'(bitOf(12)));
    statusClr = '1; tick(); statusClr = 0;

    // R7 shared line OR
    setRoute(2, 20); setRoute(3, 20); chLevel = 4'b1100;
    chEvent = 4'b1100; tick(); chEvent = 0;
    chk("R7 shared high", 64'(irqLines), 64'(bitOf(20)));
    statusClr = 4'b0100; tick(); statusClr = 0;
    chk("R7 one source left", 64'(irqLines), 64'(bitOf(20)));
    statusClr = 4'b1000; tick(); statusClr = 0;
    chk("R7 all cleared", 64'(irqLines), 0);
    chLevel = 0;

    // R8 single message
    for (int c = 0; c < NCH; c++)
      chMsgReg[c*64 +: 64] = {32'hA000_0000 + 32'(c * 16), 32'h1234_0000 + 32'(c)};
    chMsgEn = 4'b0100; chEvent = 4'b0100; tick(); chEvent = 0;
    chk("R8 no line", 64'(irqLines), 0);
    chk("R8 not yet valid", 64'(msgValid), 0);
    tick();
    chk("R8 valid", 64'(msgValid), 1);
    chk("R8 addr/data", {msgAddr, msgData}, {32'hA000_0020, 32'h1234_0002});
    msgReady = 1; tick(); msgReady = 0;
    chk("R8 drained", 64'(msgValid), 0);

    // R9 priority and hold
    chMsgEn = '1; chEvent = 4'b1011; tick(); chEvent = 0;
    tick();
    chk("R9 first is ch0", {msgAddr, msgData}, {32'hA000_0000, 32'h1234_0000});
    tick(); tick();
    chk("R9 held under backpressure", {31'b0, msgValid, msgAddr, msgData}, {31'b0, 1'b1, 32'hA000_0000, 32'h1234_0000});
    msgReady = 1; tick();
    chk("R9 second is ch1", {31'b0, msgValid, msgData}, {31'b0, 1'b1, 32'h1234_0001});
    tick();
    chk("R9 third is ch3", {31'b0, msgValid, msgData}, {31'b0, 1'b1, 32'h1234_0003});
    tick();
    chk("R9 empty", 64'(msgValid), 0);
    msgReady = 0; chMsgEn = 0;

    // R10 external legacy inputs
    extTimerIn = 1; tick();
    chk("R10 ext timer pass", 64'(irqLines), 64'(bitOf(0)));
    extTimerIn = 0; extClockIn = 1; tick();
    chk("R10 ext clock pass", 64'(irqLines), 64'(bitOf(8)));
    legacyMode = 1; extTimerIn = 1; tick();
    chk("R10 masked in legacy", 64'(irqLines), 0);
    chk("R10 legacyTimerEn low", 64'(legacyTimerEn), 0);
    extTimerIn = 0; legacyMode = 0; tick();
    chk("R10 line 8 restored", 64'(irqLines), 64'(bitOf(8)));
    chk("R10 legacyTimerEn high", 64'(legacyTimerEn), 1);
    extClockIn = 0; tick();
    chk("R10 line 8 follows", 64'(irqLines), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule